// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit carries out the three return-from-trap operations of a core that has machine, supervisor and user privilege levels, an optional hypervisor with a virtualization bit, double-trap protection and landing-pad tracking. These are the supervisor return, the machine return and the return from the non-maskable-interrupt handler. The pipeline supplies the current privilege, the virtualization bit, the relevant status fields, the three saved exception PCs and the extension enables, and it pulses a request with the return kind.

The unit first checks whether the return is legal. It then picks the redirect PC and works out the target privilege and virtualization mode. It also rewrites the interrupt-enable stack, MPRV, the double-trap bits, the saved virtualization bit and the landing-pad state. All results are computed combinationally and committed together on the next clock edge, so the rest of the core sees one coherent update along with the redirect.

A request is accepted in every cycle, and no back-pressure is applied. Results appear exactly one cycle after the request. Between requests, all outputs hold their last committed values.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, ret_done and ret_fault are 0, ret_cause is 0, redirect_pc is 0, nxt_priv is 3 (machine) and every other nxt_* output is 0. Privilege codes are 0 user, 1 supervisor, 3 machine.
- R2: The return kind is encoded as 0 supervisor return, 1 machine return, 2 non-maskable return and 3 none. A request with kind 0, 1 or 2 gives a one-cycle ret_done pulse on the next clock edge. A request with kind 3, or a cycle with no request, gives no pulse and leaves every output unchanged.
- R3: The supervisor return checks run in this priority order. First, privilege user gives cause 2 (illegal instruction). Second, when compressed support is off and bit 1 of the redirect PC is set, the cause is 0 (misaligned). Third, TSR set below machine gives cause 2. Fourth, virtual mode with VTSR set gives cause 22 (virtual instruction).
- R4: The machine return and the non-maskable return give cause 2 when the current privilege is not machine. Otherwise they give cause 0 when compressed support is off and bit 1 of the redirect PC is set.
- R5: The redirect PC is sepc, mepc or mnepc for kinds 0, 1 and 2 respectively, with bit 0 cleared.
- R6: On a faulting return, ret_fault is 1, redirect_pc is 0 and every nxt_* output equals the corresponding current input.
- R7: A supervisor return sets the target privilege to {0,SPP}. It copies SPIE into SIE, sets SPIE to 1, clears SPP and clears MPRV.
- R8: A supervisor return from non-virtual mode with the hypervisor present takes the new virtualization bit from SPV and clears SPV. Otherwise the virtualization bit and SPV are unchanged.
- R9: A machine return targets MPP. The new virtualization bit is MPV AND (MPP is not machine). It copies MPIE into MIE and sets MPIE to 1. MPP becomes user when user mode exists and machine otherwise. MPV is cleared, and MPRV is cleared only when the target is below machine.
- R10: A non-maskable return targets MNPP. The new virtualization bit is MNPV AND (MNPP is not machine). It sets NMIE, and it clears MPRV only when the target is below machine.
- R11: With the supervisor double-trap extension enabled, a supervisor return always clears SDT. It also clears the virtual-supervisor SDT when it leaves non-virtual mode for virtual user mode. The two machine-level returns clear SDT when the target is user, virtual supervisor or virtual user, and they clear the virtual-supervisor SDT when the target is virtual user.
- R12: With the machine double-trap extension enabled, a machine return always clears MDT. A non-maskable return clears MDT only when the target is below machine, and a supervisor return clears MDT only when executed in machine mode.
- R13: The landing-pad flag elp takes the saved bit of the return kind (SPELP, MPELP or MNPELP) when cfg_lp_en bit {new virt, new priv} is set, and it is otherwise kept. The saved bit of the executed kind is always cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | Return request strobe |
| ret_kind | input | 2 | Return kind (0 supervisor, 1 machine, 2 non-maskable, 3 none) |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization bit |
| cur_sie | input | 1 | Supervisor interrupt enable |
| cur_spie | input | 1 | Supervisor previous interrupt enable |
| cur_spp | input | 1 | Supervisor previous privilege |
| cur_mie | input | 1 | Machine interrupt enable |
| cur_mpie | input | 1 | Machine previous interrupt enable |
| cur_mpp | input | 2 | Machine previous privilege |
| cur_mpv | input | 1 | Machine previous virtualization |
| cur_mprv | input | 1 | Modify-privilege bit |
| cur_tsr | input | 1 | Trap supervisor return |
| cur_sdt | input | 1 | Supervisor double-trap bit |
| cur_mdt | input | 1 | Machine double-trap bit |
| cur_spv | input | 1 | Hypervisor saved virtualization bit |
| cur_vtsr | input | 1 | Trap supervisor return in virtual mode |
| cur_vs_sdt | input | 1 | Virtual-supervisor double-trap bit |
| cur_nmie | input | 1 | Non-maskable interrupt enable |
| cur_mnpp | input | 2 | Non-maskable previous privilege |
| cur_mnpv | input | 1 | Non-maskable previous virtualization |
| cur_spelp | input | 1 | Saved landing-pad bit, supervisor |
| cur_mpelp | input | 1 | Saved landing-pad bit, machine |
| cur_mnpelp | input | 1 | Saved landing-pad bit, non-maskable |
| cur_elp | input | 1 | Expected-landing-pad flag |
| cfg_has_c | input | 1 | Compressed instructions supported |
| cfg_has_u | input | 1 | User mode present |
| cfg_has_h | input | 1 | Hypervisor present |
| cfg_ssdt | input | 1 | Supervisor double-trap extension enabled |
| cfg_smdt | input | 1 | Machine double-trap extension enabled |
| cfg_lp_en | input | 8 | Landing-pad enable per {virt, priv} |
| sepc | input | XLEN | Supervisor exception PC |
| mepc | input | XLEN | Machine exception PC |
| mnepc | input | XLEN | Non-maskable exception PC |
| ret_done | output | 1 | Return committed this cycle |
| ret_fault | output | 1 | Return raised an exception |
| ret_cause | output | 5 | Exception cause |
| redirect_pc | output | XLEN | Return target PC |
| nxt_priv | output | 2 | New privilege |
| nxt_virt | output | 1 | New virtualization bit |
| nxt_sie | output | 1 | New SIE |
| nxt_spie | output | 1 | New SPIE |
| nxt_spp | output | 1 | New SPP |
| nxt_mie | output | 1 | New MIE |
| nxt_mpie | output | 1 | New MPIE |
| nxt_mpp | output | 2 | New MPP |
| nxt_mpv | output | 1 | New MPV |
| nxt_mprv | output | 1 | New MPRV |
| nxt_sdt | output | 1 | New SDT |
| nxt_mdt | output | 1 | New MDT |
| nxt_spv | output | 1 | New SPV |
| nxt_vs_sdt | output | 1 | New virtual-supervisor SDT |
| nxt_nmie | output | 1 | New NMIE |
| nxt_spelp | output | 1 | New SPELP |
| nxt_mpelp | output | 1 | New MPELP |
| nxt_mnpelp | output | 1 | New MNPELP |
| nxt_elp | output | 1 | New expected-landing-pad flag |

## Verification
Every internal decision of this unit is visible at the ports one cycle after the request. A wrong legality decision shows up as a wrong ret_fault or ret_cause, and a wrong target shows up as a wrong nxt_priv or nxt_virt, both on the ret_done cycle. A field rule taken from the wrong return kind leaves a stale or wrongly cleared status bit in that same cycle, and a spurious commit shows as an output that moves when it should have held. Each scenario therefore sets up one status pattern, issues a single return and compares the whole committed record against values derived from the rules.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    RK_SRET  = 2'd0,
    RK_MRET  = 2'd1,
    RK_MNRET = 2'd2,
    RK_NONE  = 2'd3
  } ret_kind_e;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRTINS  = 5'd22;

  typedef struct packed {
    logic [1:0] priv;
    logic       virt;
    logic       sie;
    logic       spie;
    logic       spp;
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       mpv;
    logic       mprv;
    logic       sdt;
    logic       mdt;
    logic       spv;
    logic       vs_sdt;
    logic       nmie;
    logic       spelp;
    logic       mpelp;
    logic       mnpelp;
    logic       elp;
  } trp_state_t;
endpackage

// File: rtl/trp_legality.sv
module trp_legality
  import trp_pkg::*;
(
  input  logic [1:0]         kind,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic               tsr,
  input  logic               vtsr,
  input  logic               has_c,
  input  logic               pc_bit1,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  logic misal;

  always_comb begin
    misal = !has_c && pc_bit1;
    fault = 1'b0;
    cause = CAUSE_MISALIGN;
    unique case (kind)
      RK_SRET: begin
        if (priv == PRIV_U) begin
          fault = 1'b1;
          cause = CAUSE_ILLEGAL;
        end else if (misal) begin
          fault = 1'b1;
          cause = CAUSE_MISALIGN;
        end else if (tsr && priv != PRIV_M) begin
          fault = 1'b1;
          cause = CAUSE_ILLEGAL;
        end else if (virt && vtsr) begin
          fault = 1'b1;
          cause = CAUSE_VIRTINS;
        end
      end
      RK_MRET, RK_MNRET: begin
        if (priv != PRIV_M) begin
          fault = 1'b1;
          cause = CAUSE_ILLEGAL;
        end else if (misal) begin
          fault = 1'b1;
          cause = CAUSE_MISALIGN;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trp_field_update.sv
module trp_field_update
  import trp_pkg::*;
#(
  parameter int LP_IDX_W = 3
) (
  input  logic [1:0]            kind,
  input  trp_state_t            cur,
  input  logic [1:0]            mnpp,
  input  logic                  mnpv,
  input  logic                  has_u,
  input  logic                  has_h,
  input  logic                  ssdt,
  input  logic                  smdt,
  input  logic [2**LP_IDX_W-1:0] lp_en,
  output trp_state_t            nxt
);
  logic [1:0] tgt_priv;
  logic       tgt_virt;
  logic       saved_lp;
  logic       mlvl;
  logic [LP_IDX_W-1:0] lp_idx;

  always_comb begin
    nxt      = cur;
    tgt_priv = cur.priv;
    tgt_virt = cur.virt;
    saved_lp = cur.elp;
    mlvl     = 1'b0;
    unique case (kind)
      RK_SRET: begin
        tgt_priv = {1'b0, cur.spp};
        if (has_h && !cur.virt) begin
          tgt_virt = cur.spv;
          nxt.spv  = 1'b0;
        end
        nxt.sie  = cur.spie;
        nxt.spie = 1'b1;
        nxt.spp  = 1'b0;
        nxt.mprv = 1'b0;
        if (ssdt) begin
          nxt.sdt = 1'b0;
          if (has_h && !cur.virt && cur.spv && tgt_priv == PRIV_U)
            nxt.vs_sdt = 1'b0;
        end
        if (smdt && cur.priv == PRIV_M) nxt.mdt = 1'b0;
        saved_lp  = cur.spelp;
        nxt.spelp = 1'b0;
      end
      RK_MRET: begin
        mlvl     = 1'b1;
        tgt_priv = cur.mpp;
        tgt_virt = cur.mpv && (cur.mpp != PRIV_M);
        nxt.mie  = cur.mpie;
        nxt.mpie = 1'b1;
        nxt.mpp  = has_u ? PRIV_U : PRIV_M;
        nxt.mpv  = 1'b0;
        if (tgt_priv != PRIV_M) nxt.mprv = 1'b0;
        if (smdt) nxt.mdt = 1'b0;
        saved_lp  = cur.mpelp;
        nxt.mpelp = 1'b0;
      end
      RK_MNRET: begin
        mlvl     = 1'b1;
        tgt_priv = mnpp;
        tgt_virt = mnpv && (mnpp != PRIV_M);
        nxt.nmie = 1'b1;
        if (tgt_priv != PRIV_M) nxt.mprv = 1'b0;
        if (smdt && tgt_priv != PRIV_M) nxt.mdt = 1'b0;
        saved_lp   = cur.mnpelp;
        nxt.mnpelp = 1'b0;
      end
      default: ;
    endcase

    if (mlvl && ssdt) begin
      if (tgt_priv == PRIV_U ||
          (tgt_virt && (tgt_priv == PRIV_S || tgt_priv == PRIV_U)))
        nxt.sdt = 1'b0;
      if (tgt_virt && tgt_priv == PRIV_U) nxt.vs_sdt = 1'b0;
    end

    nxt.priv = tgt_priv;
    nxt.virt = tgt_virt;
    lp_idx   = {tgt_virt, tgt_priv};
    if (lp_en[lp_idx]) nxt.elp = saved_lp;
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic [1:0]      ret_kind,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic            cur_sie,
  input  logic            cur_spie,
  input  logic            cur_spp,
  input  logic            cur_mie,
  input  logic            cur_mpie,
  input  logic [1:0]      cur_mpp,
  input  logic            cur_mpv,
  input  logic            cur_mprv,
  input  logic            cur_tsr,
  input  logic            cur_sdt,
  input  logic            cur_mdt,
  input  logic            cur_spv,
  input  logic            cur_vtsr,
  input  logic            cur_vs_sdt,
  input  logic            cur_nmie,
  input  logic [1:0]      cur_mnpp,
  input  logic            cur_mnpv,
  input  logic            cur_spelp,
  input  logic            cur_mpelp,
  input  logic            cur_mnpelp,
  input  logic            cur_elp,
  input  logic            cfg_has_c,
  input  logic            cfg_has_u,
  input  logic            cfg_has_h,
  input  logic            cfg_ssdt,
  input  logic            cfg_smdt,
  input  logic [7:0]      cfg_lp_en,
  input  logic [XLEN-1:0] sepc,
  input  logic [XLEN-1:0] mepc,
  input  logic [XLEN-1:0] mnepc,
  output logic            ret_done,
  output logic            ret_fault,
  output logic [4:0]      ret_cause,
  output logic [XLEN-1:0] redirect_pc,
  output logic [1:0]      nxt_priv,
  output logic            nxt_virt,
  output logic            nxt_sie,
  output logic            nxt_spie,
  output logic            nxt_spp,
  output logic            nxt_mie,
  output logic            nxt_mpie,
  output logic [1:0]      nxt_mpp,
  output logic            nxt_mpv,
  output logic            nxt_mprv,
  output logic            nxt_sdt,
  output logic            nxt_mdt,
  output logic            nxt_spv,
  output logic            nxt_vs_sdt,
  output logic            nxt_nmie,
  output logic            nxt_spelp,
  output logic            nxt_mpelp,
  output logic            nxt_mnpelp,
  output logic            nxt_elp
);
  localparam int LP_IDX_W = 3;
  localparam logic [XLEN-1:0] PC_ALIGN_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};

  trp_state_t          cur_st, upd_st, st_q;
  logic                chk_fault;
  logic [CAUSE_W-1:0]  chk_cause;
  logic [XLEN-1:0]     tgt_pc;
  logic                accept;

  assign cur_st = '{priv: cur_priv, virt: cur_virt, sie: cur_sie, spie: cur_spie,
                    spp: cur_spp, mie: cur_mie, mpie: cur_mpie, mpp: cur_mpp,
                    mpv: cur_mpv, mprv: cur_mprv, sdt: cur_sdt, mdt: cur_mdt,
                    spv: cur_spv, vs_sdt: cur_vs_sdt, nmie: cur_nmie,
                    spelp: cur_spelp, mpelp: cur_mpelp, mnpelp: cur_mnpelp,
                    elp: cur_elp};

  always_comb begin
    unique case (ret_kind)
      RK_SRET:  tgt_pc = sepc & PC_ALIGN_MASK;
      RK_MRET:  tgt_pc = mepc & PC_ALIGN_MASK;
      RK_MNRET: tgt_pc = mnepc & PC_ALIGN_MASK;
      default:  tgt_pc = '0;
    endcase
  end

  assign accept = ret_valid && (ret_kind != RK_NONE);

  trp_legality u_legal (
    .kind    (ret_kind),
    .priv    (cur_priv),
    .virt    (cur_virt),
    .tsr     (cur_tsr),
    .vtsr    (cur_vtsr),
    .has_c   (cfg_has_c),
    .pc_bit1 (tgt_pc[1]),
    .fault   (chk_fault),
    .cause   (chk_cause)
  );

  trp_field_update #(.LP_IDX_W(LP_IDX_W)) u_update (
    .kind  (ret_kind),
    .cur   (cur_st),
    .mnpp  (cur_mnpp),
    .mnpv  (cur_mnpv),
    .has_u (cfg_has_u),
    .has_h (cfg_has_h),
    .ssdt  (cfg_ssdt),
    .smdt  (cfg_smdt),
    .lp_en (cfg_lp_en),
    .nxt   (upd_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_done    <= 1'b0;
      ret_fault   <= 1'b0;
      ret_cause   <= '0;
      redirect_pc <= '0;
      st_q        <= '0;
      st_q.priv   <= PRIV_M;
    end else begin
      ret_done <= accept;
      if (accept) begin
        ret_fault   <= chk_fault;
        ret_cause   <= chk_fault ? chk_cause : '0;
        redirect_pc <= chk_fault ? '0 : tgt_pc;
        st_q        <= chk_fault ? cur_st : upd_st;
      end
    end
  end

  assign nxt_priv   = st_q.priv;
  assign nxt_virt   = st_q.virt;
  assign nxt_sie    = st_q.sie;
  assign nxt_spie   = st_q.spie;
  assign nxt_spp    = st_q.spp;
  assign nxt_mie    = st_q.mie;
  assign nxt_mpie   = st_q.mpie;
  assign nxt_mpp    = st_q.mpp;
  assign nxt_mpv    = st_q.mpv;
  assign nxt_mprv   = st_q.mprv;
  assign nxt_sdt    = st_q.sdt;
  assign nxt_mdt    = st_q.mdt;
  assign nxt_spv    = st_q.spv;
  assign nxt_vs_sdt = st_q.vs_sdt;
  assign nxt_nmie   = st_q.nmie;
  assign nxt_spelp  = st_q.spelp;
  assign nxt_mpelp  = st_q.mpelp;
  assign nxt_mnpelp = st_q.mnpelp;
  assign nxt_elp    = st_q.elp;
endmodule

// File: rtl/trap_return_chk.sv
module trap_return_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ret_valid,
  input logic [1:0] ret_kind,
  input logic [1:0] cur_priv,
  input logic       ret_done,
  input logic       ret_fault,
  input logic [4:0] ret_cause,
  input logic       pc_lsb,
  input logic       nxt_spie,
  input logic       nxt_spp,
  input logic       nxt_mprv,
  input logic       nxt_mpie,
  input logic       nxt_mpv,
  input logic       nxt_nmie
);
  // R2
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid || ret_kind == 2'd3) |=> !ret_done);

  // R4
  m_level_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && (ret_kind == 2'd1 || ret_kind == 2'd2) && cur_priv != 2'd3)
      |=> (ret_done && ret_fault && ret_cause == 5'd2));

  // R6
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fault && ret_done |-> !pc_lsb);

  // R5
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && !ret_fault) |-> !pc_lsb);

  // R7
  sret_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind == 2'd0 && cur_priv == 2'd3)
      |=> (ret_done && !ret_fault && nxt_spie && !nxt_spp && !nxt_mprv));

  // R9
  mret_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && !ret_fault && $past(ret_kind) == 2'd1) |-> (nxt_mpie && !nxt_mpv));

  // R10
  mnret_nmie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && !ret_fault && $past(ret_kind) == 2'd2) |-> nxt_nmie);
endmodule

bind trap_return_unit trap_return_chk u_trap_return_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ret_valid (ret_valid),
  .ret_kind  (ret_kind),
  .cur_priv  (cur_priv),
  .ret_done  (ret_done),
  .ret_fault (ret_fault),
  .ret_cause (ret_cause),
  .pc_lsb    (redirect_pc[0]),
  .nxt_spie  (nxt_spie),
  .nxt_spp   (nxt_spp),
  .nxt_mprv  (nxt_mprv),
  .nxt_mpie  (nxt_mpie),
  .nxt_mpv   (nxt_mpv),
  .nxt_nmie  (nxt_nmie)
);

// File: tb/tb_trap_return_unit.sv
`timescale 1ns/1ps
module tb_trap_return_unit;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret_valid = 1'b0;
  logic [1:0] ret_kind = 2'd3;
  logic [1:0] c_priv, c_mpp, c_mnpp;
  logic c_virt, c_sie, c_spie, c_spp, c_mie, c_mpie, c_mpv, c_mprv, c_tsr;
  logic c_sdt, c_mdt, c_spv, c_vtsr, c_vs_sdt, c_nmie, c_mnpv;
  logic c_spelp, c_mpelp, c_mnpelp, c_elp;
  logic has_c, has_u, has_h, ssdt, smdt;
  logic [7:0] lp_en;
  logic [XLEN-1:0] sepc, mepc, mnepc;

  logic ret_done, ret_fault;
  logic [4:0] ret_cause;
  logic [XLEN-1:0] redirect_pc;
  logic [1:0] n_priv, n_mpp;
  logic n_virt, n_sie, n_spie, n_spp, n_mie, n_mpie, n_mpv, n_mprv, n_sdt, n_mdt;
  logic n_spv, n_vs_sdt, n_nmie, n_spelp, n_mpelp, n_mnpelp, n_elp;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .cur_priv(c_priv), .cur_virt(c_virt), .cur_sie(c_sie), .cur_spie(c_spie),
    .cur_spp(c_spp), .cur_mie(c_mie), .cur_mpie(c_mpie), .cur_mpp(c_mpp),
    .cur_mpv(c_mpv), .cur_mprv(c_mprv), .cur_tsr(c_tsr), .cur_sdt(c_sdt),
    .cur_mdt(c_mdt), .cur_spv(c_spv), .cur_vtsr(c_vtsr), .cur_vs_sdt(c_vs_sdt),
    .cur_nmie(c_nmie), .cur_mnpp(c_mnpp), .cur_mnpv(c_mnpv), .cur_spelp(c_spelp),
    .cur_mpelp(c_mpelp), .cur_mnpelp(c_mnpelp), .cur_elp(c_elp),
    .cfg_has_c(has_c), .cfg_has_u(has_u), .cfg_has_h(has_h), .cfg_ssdt(ssdt),
    .cfg_smdt(smdt), .cfg_lp_en(lp_en), .sepc(sepc), .mepc(mepc), .mnepc(mnepc),
    .ret_done(ret_done), .ret_fault(ret_fault), .ret_cause(ret_cause),
    .redirect_pc(redirect_pc), .nxt_priv(n_priv), .nxt_virt(n_virt),
    .nxt_sie(n_sie), .nxt_spie(n_spie), .nxt_spp(n_spp), .nxt_mie(n_mie),
    .nxt_mpie(n_mpie), .nxt_mpp(n_mpp), .nxt_mpv(n_mpv), .nxt_mprv(n_mprv),
    .nxt_sdt(n_sdt), .nxt_mdt(n_mdt), .nxt_spv(n_spv), .nxt_vs_sdt(n_vs_sdt),
    .nxt_nmie(n_nmie), .nxt_spelp(n_spelp), .nxt_mpelp(n_mpelp),
    .nxt_mnpelp(n_mnpelp), .nxt_elp(n_elp)
  );

  task automatic ck(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    c_priv = 2'd3; c_virt = 0; c_sie = 0; c_spie = 0; c_spp = 0; c_mie = 0;
    c_mpie = 0; c_mpp = 0; c_mpv = 0; c_mprv = 0; c_tsr = 0; c_sdt = 0;
    c_mdt = 0; c_spv = 0; c_vtsr = 0; c_vs_sdt = 0; c_nmie = 0; c_mnpp = 0;
    c_mnpv = 0; c_spelp = 0; c_mpelp = 0; c_mnpelp = 0; c_elp = 0;
    has_c = 1; has_u = 1; has_h = 1; ssdt = 1; smdt = 1; lp_en = 8'h00;
    sepc = 64'h1001; mepc = 64'h2001; mnepc = 64'h3001;
  endtask

  // Drives one request for one cycle; results are sampled on return.
  task automatic issue(input logic [1:0] k);
    @(negedge clk);
    ret_valid = 1'b1;
    ret_kind  = k;
    @(negedge clk);
    ret_valid = 1'b0;
    ret_kind  = 2'd3;
  endtask

  task automatic t_reset();
    ck("R1 done", ret_done, 0);
    ck("R1 fault", ret_fault, 0);
    ck("R1 cause", ret_cause, 0);
    ck("R1 pc", redirect_pc, 0);
    ck("R1 priv", n_priv, 3);
    ck("R1 fields", {n_virt, n_sie, n_spie, n_mpie, n_mpp, n_nmie, n_elp}, 0);
  endtask

  task automatic t_sret_basic();
    defaults();
    c_priv = 2'd1; c_spp = 1; c_spie = 1; c_mprv = 1; c_spv = 1; c_sdt = 1;
    c_vs_sdt = 1; c_mdt = 1; c_spelp = 1;
    issue(2'd0);
    ck("R2 done", ret_done, 1);
    ck("R3 nofault", ret_fault, 0);
    ck("R5 pc", redirect_pc, 64'h1000);
    ck("R7 priv", n_priv, 1);
    ck("R7 sie/spie/spp/mprv", {n_sie, n_spie, n_spp, n_mprv}, 4'b1100);
    ck("R8 virt/spv", {n_virt, n_spv}, 2'b10);
    ck("R11 sdt/vs_sdt", {n_sdt, n_vs_sdt}, 2'b01);
    ck("R12 mdt kept", n_mdt, 1);
    ck("R13 elp/spelp", {n_elp, n_spelp}, 2'b00);
    @(negedge clk);
    ck("R2 pulse ends", ret_done, 0);
  endtask

  task automatic t_sret_vu();
    defaults();
    c_priv = 2'd1; c_spv = 1; c_spp = 0; c_vs_sdt = 1; c_spelp = 1; lp_en = 8'h10;
    issue(2'd0);
    ck("R7 priv U", n_priv, 0);
    ck("R8 virt", n_virt, 1);
    ck("R11 vs_sdt cleared", n_vs_sdt, 0);
    ck("R13 elp restored", {n_elp, n_spelp}, 2'b10);
    defaults();
    c_priv = 2'd1; c_virt = 1; c_spv = 1; c_spp = 1;
    issue(2'd0);
    ck("R8 virt kept", {n_virt, n_spv}, 2'b11);
    defaults();
    c_priv = 2'd3; c_mdt = 1;
    issue(2'd0);
    ck("R12 sret in M clears mdt", n_mdt, 0);
  endtask

  task automatic t_sret_faults();
    defaults();
    c_priv = 2'd0; c_sie = 1; c_spie = 0; has_c = 0; sepc = 64'h1002;
    issue(2'd0);
    ck("R3 user fault", {ret_fault, ret_cause}, {1'b1, 5'd2});
    ck("R6 pc zero", redirect_pc, 0);
    ck("R6 fields held", {n_priv, n_sie, n_spie}, {2'd0, 1'b1, 1'b0});
    defaults();
    c_priv = 2'd1; has_c = 0; sepc = 64'h1003; c_virt = 1; c_vtsr = 1;
    issue(2'd0);
    ck("R3 misaligned first", {ret_fault, ret_cause}, {1'b1, 5'd0});
    defaults();
    c_priv = 2'd1; c_tsr = 1; sepc = 64'h1000;
    issue(2'd0);
    ck("R3 tsr", {ret_fault, ret_cause}, {1'b1, 5'd2});
    defaults();
    c_priv = 2'd3; c_tsr = 1;
    issue(2'd0);
    ck("R3 tsr in M ok", ret_fault, 0);
    defaults();
    c_priv = 2'd1; c_virt = 1; c_vtsr = 1;
    issue(2'd0);
    ck("R3 vtsr", {ret_fault, ret_cause}, {1'b1, 5'd22});
  endtask

  task automatic t_mret();
    defaults();
    c_mpp = 0; c_mpv = 1; c_mpie = 1; c_mprv = 1; c_sdt = 1; c_vs_sdt = 1;
    c_mdt = 1; c_mpelp = 1; lp_en = 8'h10;
    issue(2'd1);
    ck("R5 pc", redirect_pc, 64'h2000);
    ck("R9 priv/virt", {n_priv, n_virt}, 3'b001);
    ck("R9 mie/mpie/mpp/mpv/mprv", {n_mie, n_mpie, n_mpp, n_mpv, n_mprv}, 6'b110000);
    ck("R11 sdt/vs_sdt VU", {n_sdt, n_vs_sdt}, 2'b00);
    ck("R12 mdt", n_mdt, 0);
    ck("R13 elp/mpelp", {n_elp, n_mpelp}, 2'b10);
    defaults();
    has_u = 0; c_mpp = 3; c_mpv = 1; c_mprv = 1; c_sdt = 1; c_mdt = 1; c_mpelp = 1;
    issue(2'd1);
    ck("R9 to M", {n_priv, n_virt, n_mpp, n_mprv}, 6'b110111);
    ck("R11 sdt kept", n_sdt, 1);
    ck("R12 mdt always", n_mdt, 0);
    ck("R13 elp kept", {n_elp, n_mpelp}, 2'b00);
    defaults();
    c_mpp = 1; c_sdt = 1;
    issue(2'd1);
    ck("R11 HS target keeps sdt", {n_priv, n_sdt}, 3'b011);
    defaults();
    c_priv = 2'd1;
    issue(2'd1);
    ck("R4 mret priv", {ret_fault, ret_cause}, {1'b1, 5'd2});
    defaults();
    has_c = 0; mepc = 64'h2002;
    issue(2'd1);
    ck("R4 mret misaligned", {ret_fault, ret_cause}, {1'b1, 5'd0});
  endtask

  task automatic t_mnret();
    defaults();
    c_mnpp = 1; c_mprv = 1; c_mdt = 1; c_sdt = 1; c_mnpelp = 1; lp_en = 8'h02;
    issue(2'd2);
    ck("R5 pc", redirect_pc, 64'h3000);
    ck("R10 priv/virt/nmie/mprv", {n_priv, n_virt, n_nmie, n_mprv}, 5'b01010);
    ck("R12 mdt below M", n_mdt, 0);
    ck("R11 sdt kept", n_sdt, 1);
    ck("R13 elp/mnpelp", {n_elp, n_mnpelp}, 2'b10);
    defaults();
    c_mnpp = 3; c_mnpv = 1; c_mdt = 1; c_mprv = 1;
    issue(2'd2);
    ck("R10 to M", {n_priv, n_virt, n_mprv}, 4'b1101);
    ck("R12 mdt kept at M", n_mdt, 1);
    defaults();
    c_mnpp = 1; c_mnpv = 1; c_sdt = 1; c_vs_sdt = 1;
    issue(2'd2);
    ck("R11 VS target", {n_virt, n_sdt, n_vs_sdt}, 3'b101);
    defaults();
    c_priv = 2'd0;
    issue(2'd2);
    ck("R4 mnret priv", {ret_fault, ret_cause}, {1'b1, 5'd2});
    defaults();
    has_c = 0; mnepc = 64'h3002;
    issue(2'd2);
    ck("R4 mnret misaligned", {ret_fault, ret_cause}, {1'b1, 5'd0});
  endtask

  task automatic t_none();
    defaults();
    c_priv = 2'd1; c_spp = 1;
    issue(2'd0);
    ck("R2 setup", {ret_done, n_priv}, 3'b101);
    defaults();
    c_priv = 2'd0;
    issue(2'd3);
    ck("R2 kind3 no done", ret_done, 0);
    ck("R2 kind3 holds", {n_priv, redirect_pc[15:0]}, {2'd1, 16'h1000});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sret_basic();
    t_sret_vu();
    t_sret_faults();
    t_mret();
    t_mnret();
    t_none();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule